// File: doc/BRIEF.md
# Pad Boundary-Scan Register

This block sits between the core-side I/O of a small pad ring and the pads themselves. The ring has a parameterised number of general-purpose bidirectional pads (four by default), a serial port with one receive input and one transmit output, and a two-wire bus with a data line and a clock line, both bidirectional. Every bidirectional pad is carried as three separate lines: the value read from the pad, the value driven to it, and its output enable. Each line owns one scan cell. The test-access pins are not part of the chain.

A TAP controller outside the block supplies the capture, shift and update strobes for the data register, a synchronous test-logic-reset strobe and the current instruction. The block returns the serial output. A three-state mode machine decodes the instruction. In MODE_PASS every line connects core and pad directly and the strobes are ignored. In MODE_SAMPLE core and pads stay connected while the chain captures, shifts and updates. In MODE_EXTEST the pad outputs and output enables come from the update latches, and so do the core-side inputs. The external-test and internal-test instructions share this code. Transitions: from any state the register moves to MODE_EXTEST when the instruction equals the external-test code, to MODE_SAMPLE when it equals the sample code, and to MODE_PASS for any other code or when test-logic-reset is high. It makes one move per TCK edge.

Each cell has a capture/shift flip-flop and a separate update latch. A pad therefore changes only when an update is applied.

Top module: `bs_pad_chain`

## Requirements
- R1: The chain length is 3*N_GPIO+8 (20 by default). While the register is selected and shift is high, each TCK edge moves every cell one place toward the output: the cell at the highest index loads TDI and TDO always shows cell 0. A word shifted in LSB first therefore lands bit for bit in the cells after one full chain length, while the previous contents appear on TDO LSB first.
- R2: Cell layout with N=N_GPIO, input cells first:
  - Cells 0..N-1 hold the GPIO pad inputs, cell N the receive input, cell N+1 the data-line input and cell N+2 the clock-line input (NI=N+3).
  - Cells NI..NI+N-1 hold the GPIO outputs, then come the transmit output, the data-line output and the clock-line output.
  - The enable cells start at NI+N+3: the N GPIO enables, then the data-line enable and the clock-line enable.
- R3: A capture strobe with the register selected loads the input cells from the pad inputs and the output and enable cells from the core outputs and enables. Capture takes priority over a shift in the same cycle.
- R4: In MODE_EXTEST (instruction code 0) the pad outputs and enables show the output and enable update latches, and the core-side inputs show the input update latches. Core outputs and pad inputs have no effect on these.
- R5: The update latches load the whole chain only on an update strobe with the register selected. When update and shift fall in the same cycle, the latches take the pre-shift contents while the chain shifts.
- R6: In MODE_SAMPLE (instruction code 2) every line passes straight through between core and pad during capture, shift and update.
- R7: Under any other instruction code every line passes straight through, and the capture, shift and update strobes change neither the chain nor the latches.
- R8: An asynchronous reset or the test-logic-reset strobe clears the chain and all update latches and puts the mode machine in MODE_PASS.
- R9: A change of instruction takes effect at the first TCK edge after it is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low reset |
| tlr | input | 1 | Synchronous test-logic-reset strobe |
| ir | input | IR_W | Current instruction code |
| capture_dr | input | 1 | Capture strobe for the data register |
| shift_dr | input | 1 | Shift strobe for the data register |
| update_dr | input | 1 | Update strobe for the data register |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (cell 0) |
| core_gpio_o | input | N_GPIO | Core GPIO output values |
| core_gpio_oe | input | N_GPIO | Core GPIO output enables |
| core_gpio_i | output | N_GPIO | GPIO input values seen by the core |
| pad_gpio_i | input | N_GPIO | GPIO values read from the pads |
| pad_gpio_o | output | N_GPIO | GPIO values driven to the pads |
| pad_gpio_oe | output | N_GPIO | GPIO pad output enables |
| core_tx | input | 1 | Core transmit value |
| pad_tx | output | 1 | Transmit pad value |
| pad_rx | input | 1 | Receive pad value |
| core_rx | output | 1 | Receive value seen by the core |
| core_sda_o | input | 1 | Core data-line output |
| core_sda_oe | input | 1 | Core data-line enable |
| core_sda_i | output | 1 | Data-line input seen by the core |
| pad_sda_i | input | 1 | Data-line pad input |
| pad_sda_o | output | 1 | Data-line pad output |
| pad_sda_oe | output | 1 | Data-line pad enable |
| core_scl_o | input | 1 | Core clock-line output |
| core_scl_oe | input | 1 | Core clock-line enable |
| core_scl_i | output | 1 | Clock-line input seen by the core |
| pad_scl_i | input | 1 | Clock-line pad input |
| pad_scl_o | output | 1 | Clock-line pad output |
| pad_scl_oe | output | 1 | Clock-line pad enable |

## Verification
Update and shift can fall in the same TCK cycle. In external test the bench raises both strobes together for one edge while the pads show an earlier pattern. The pads must then show the chain contents from before that edge. A following readout must show the chain moved by exactly one place with the TDI bit at the top. The bench also issues a test-logic-reset while the instruction is still external test. Pass-through must follow at once, and cleared latches must drive the pads one edge later.

// File: rtl/bs_pkg.sv
package bs_pkg;
    typedef enum logic [1:0] {
        MODE_PASS   = 2'd0,
        MODE_SAMPLE = 2'd1,
        MODE_EXTEST = 2'd2
    } bs_mode_e;
endpackage

// File: rtl/bs_mode_ctl.sv
module bs_mode_ctl
    import bs_pkg::*;
#(
    parameter int IR_W        = 4,
    parameter int CODE_EXTEST = 0,
    parameter int CODE_SAMPLE = 2
) (
    input  logic            tck,
    input  logic            trst_n,
    input  logic            tlr,
    input  logic [IR_W-1:0] ir,
    output logic            sel,
    output logic            ext
);
    bs_mode_e state_q, state_d;

    // next-state decode
    always_comb begin
        if (tlr)
            state_d = MODE_PASS;
        else if (ir == IR_W'(CODE_EXTEST))
            state_d = MODE_EXTEST;
        else if (ir == IR_W'(CODE_SAMPLE))
            state_d = MODE_SAMPLE;
        else
            state_d = MODE_PASS;
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) state_q <= MODE_PASS;
        else         state_q <= state_d;
    end

    // per-state outputs
    always_comb begin
        sel = 1'b0;
        ext = 1'b0;
        unique case (state_q)
            MODE_PASS:   begin sel = 1'b0; ext = 1'b0; end
            MODE_SAMPLE: begin sel = 1'b1; ext = 1'b0; end
            MODE_EXTEST: begin sel = 1'b1; ext = 1'b1; end
            default:     begin sel = 1'b0; ext = 1'b0; end
        endcase
    end

    AST_TLR_TO_PASS: assert property (@(posedge tck) disable iff (!trst_n)
        tlr |=> (!sel && !ext)); // R8

    AST_MODE_FOLLOWS_IR: assert property (@(posedge tck) disable iff (!trst_n)
        (!tlr && ir == IR_W'(CODE_EXTEST)) |=> (sel && ext)); // R9
endmodule

// File: rtl/bs_cell_chain.sv
module bs_cell_chain #(
    parameter int L  = 20,
    parameter int NI = 7
) (
    input  logic         tck,
    input  logic         trst_n,
    input  logic         tlr,
    input  logic         sel,
    input  logic         capture,
    input  logic         shift,
    input  logic         update,
    input  logic         tdi,
    input  logic [L-1:0] cap_in,
    output logic         tdo,
    output logic [L-1:0] upd
);
    logic [L-1:0] sr;
    logic [L-1:0] shin;

    for (genvar i = 0; i < L; i++) begin : g_cell
        logic cell_q;
        logic latch_q;

        if (i == L-1) begin : g_head
            assign shin[i] = tdi;
        end else begin : g_body
            assign shin[i] = sr[i+1];
        end

        always_ff @(posedge tck or negedge trst_n) begin
            if (!trst_n)                cell_q <= 1'b0;
            else if (tlr)               cell_q <= 1'b0;
            else if (sel && capture)    cell_q <= cap_in[i];
            else if (sel && shift)      cell_q <= shin[i];
        end

        always_ff @(posedge tck or negedge trst_n) begin
            if (!trst_n)                latch_q <= 1'b0;
            else if (tlr)               latch_q <= 1'b0;
            else if (sel && update)     latch_q <= cell_q;
        end

        assign sr[i]  = cell_q;
        assign upd[i] = latch_q;
    end

    assign tdo = sr[0];

    AST_TLR_CLEAR: assert property (@(posedge tck) disable iff (!trst_n)
        tlr |=> (upd == '0 && sr == '0)); // R8

    AST_UPD_HOLD: assert property (@(posedge tck) disable iff (!trst_n)
        (!(sel && update) && !tlr) |=> $stable(upd)); // R5

    AST_SHIFT_IN: assert property (@(posedge tck) disable iff (!trst_n)
        (sel && shift && !capture && !tlr) |=> (sr[L-1] == $past(tdi))); // R1

    AST_SR_IDLE: assert property (@(posedge tck) disable iff (!trst_n)
        (!(sel && (capture || shift)) && !tlr) |=> $stable(sr)); // R7

    AST_CAPTURE_IN: assert property (@(posedge tck) disable iff (!trst_n)
        (sel && capture && !tlr) |=> (sr[NI-1:0] == $past(cap_in[NI-1:0]))); // R3
endmodule

// File: rtl/bs_pad_mux.sv
module bs_pad_mux #(
    parameter int NI = 7,
    parameter int NO = 7,
    parameter int NE = 6
) (
    input  logic          ext,
    input  logic [NI-1:0] upd_in,
    input  logic [NO-1:0] upd_out,
    input  logic [NE-1:0] upd_oe,
    input  logic [NI-1:0] pad_in,
    input  logic [NO-1:0] core_out,
    input  logic [NE-1:0] core_oe,
    output logic [NI-1:0] core_in,
    output logic [NO-1:0] pad_out,
    output logic [NE-1:0] pad_oe
);
    for (genvar k = 0; k < NI; k++) begin : g_in
        assign core_in[k] = ext ? upd_in[k] : pad_in[k];
    end
    for (genvar k = 0; k < NO; k++) begin : g_out
        assign pad_out[k] = ext ? upd_out[k] : core_out[k];
    end
    for (genvar k = 0; k < NE; k++) begin : g_oe
        assign pad_oe[k] = ext ? upd_oe[k] : core_oe[k];
    end
endmodule

// File: rtl/bs_pad_chain.sv
module bs_pad_chain #(
    parameter int N_GPIO      = 4,
    parameter int IR_W        = 4,
    parameter int CODE_EXTEST = 0,
    parameter int CODE_SAMPLE = 2
) (
    input  logic              tck,
    input  logic              trst_n,
    input  logic              tlr,
    input  logic [IR_W-1:0]   ir,
    input  logic              capture_dr,
    input  logic              shift_dr,
    input  logic              update_dr,
    input  logic              tdi,
    output logic              tdo,
    input  logic [N_GPIO-1:0] core_gpio_o,
    input  logic [N_GPIO-1:0] core_gpio_oe,
    output logic [N_GPIO-1:0] core_gpio_i,
    input  logic [N_GPIO-1:0] pad_gpio_i,
    output logic [N_GPIO-1:0] pad_gpio_o,
    output logic [N_GPIO-1:0] pad_gpio_oe,
    input  logic              core_tx,
    output logic              pad_tx,
    input  logic              pad_rx,
    output logic              core_rx,
    input  logic              core_sda_o,
    input  logic              core_sda_oe,
    output logic              core_sda_i,
    input  logic              pad_sda_i,
    output logic              pad_sda_o,
    output logic              pad_sda_oe,
    input  logic              core_scl_o,
    input  logic              core_scl_oe,
    output logic              core_scl_i,
    input  logic              pad_scl_i,
    output logic              pad_scl_o,
    output logic              pad_scl_oe
);
    localparam int NI = N_GPIO + 3;   // gpio, rx, sda, scl inputs
    localparam int NO = N_GPIO + 3;   // gpio, tx, sda, scl outputs
    localparam int NE = N_GPIO + 2;   // gpio, sda, scl enables
    localparam int L  = NI + NO + NE;

    logic          sel, ext;
    logic [L-1:0]  upd;
    logic [L-1:0]  cap_in;
    logic [NI-1:0] pad_in_v,  core_in_v;
    logic [NO-1:0] core_out_v, pad_out_v;
    logic [NE-1:0] core_oe_v,  pad_oe_v;

    assign pad_in_v   = {pad_scl_i, pad_sda_i, pad_rx, pad_gpio_i};
    assign core_out_v = {core_scl_o, core_sda_o, core_tx, core_gpio_o};
    assign core_oe_v  = {core_scl_oe, core_sda_oe, core_gpio_oe};
    assign cap_in     = {core_oe_v, core_out_v, pad_in_v};

    bs_mode_ctl #(
        .IR_W(IR_W), .CODE_EXTEST(CODE_EXTEST), .CODE_SAMPLE(CODE_SAMPLE)
    ) u_mode (
        .tck(tck), .trst_n(trst_n), .tlr(tlr), .ir(ir), .sel(sel), .ext(ext)
    );

    bs_cell_chain #(.L(L), .NI(NI)) u_chain (
        .tck(tck), .trst_n(trst_n), .tlr(tlr), .sel(sel),
        .capture(capture_dr), .shift(shift_dr), .update(update_dr),
        .tdi(tdi), .cap_in(cap_in), .tdo(tdo), .upd(upd)
    );

    bs_pad_mux #(.NI(NI), .NO(NO), .NE(NE)) u_mux (
        .ext(ext),
        .upd_in(upd[NI-1:0]),
        .upd_out(upd[NI+NO-1:NI]),
        .upd_oe(upd[L-1:NI+NO]),
        .pad_in(pad_in_v),
        .core_out(core_out_v),
        .core_oe(core_oe_v),
        .core_in(core_in_v),
        .pad_out(pad_out_v),
        .pad_oe(pad_oe_v)
    );

    assign core_gpio_i = core_in_v[N_GPIO-1:0];
    assign core_rx     = core_in_v[N_GPIO];
    assign core_sda_i  = core_in_v[N_GPIO+1];
    assign core_scl_i  = core_in_v[N_GPIO+2];
    assign pad_gpio_o  = pad_out_v[N_GPIO-1:0];
    assign pad_tx      = pad_out_v[N_GPIO];
    assign pad_sda_o   = pad_out_v[N_GPIO+1];
    assign pad_scl_o   = pad_out_v[N_GPIO+2];
    assign pad_gpio_oe = pad_oe_v[N_GPIO-1:0];
    assign pad_sda_oe  = pad_oe_v[N_GPIO];
    assign pad_scl_oe  = pad_oe_v[N_GPIO+1];
endmodule

// File: tb/bs_pad_chain_bench.sv
`timescale 1ns/1ps
module bs_pad_chain_bench;
    localparam int N  = 4;
    localparam int NI = N + 3;
    localparam int NO = N + 3;
    localparam int NE = N + 2;
    localparam int L  = NI + NO + NE;

    logic tck = 1'b0;
    always #2.5 tck = ~tck;

    logic trst_n, tlr, capture_dr, shift_dr, update_dr, tdi, tdo;
    logic [3:0] ir;
    logic [N-1:0] core_gpio_o, core_gpio_oe, core_gpio_i, pad_gpio_i, pad_gpio_o, pad_gpio_oe;
    logic core_tx, pad_tx, pad_rx, core_rx;
    logic core_sda_o, core_sda_oe, core_sda_i, pad_sda_i, pad_sda_o, pad_sda_oe;
    logic core_scl_o, core_scl_oe, core_scl_i, pad_scl_i, pad_scl_o, pad_scl_oe;

    bs_pad_chain u_bs_pad_chain (
        .tck(tck), .trst_n(trst_n), .tlr(tlr), .ir(ir),
        .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
        .tdi(tdi), .tdo(tdo),
        .core_gpio_o(core_gpio_o), .core_gpio_oe(core_gpio_oe), .core_gpio_i(core_gpio_i),
        .pad_gpio_i(pad_gpio_i), .pad_gpio_o(pad_gpio_o), .pad_gpio_oe(pad_gpio_oe),
        .core_tx(core_tx), .pad_tx(pad_tx), .pad_rx(pad_rx), .core_rx(core_rx),
        .core_sda_o(core_sda_o), .core_sda_oe(core_sda_oe), .core_sda_i(core_sda_i),
        .pad_sda_i(pad_sda_i), .pad_sda_o(pad_sda_o), .pad_sda_oe(pad_sda_oe),
        .core_scl_o(core_scl_o), .core_scl_oe(core_scl_oe), .core_scl_i(core_scl_i),
        .pad_scl_i(pad_scl_i), .pad_scl_o(pad_scl_o), .pad_scl_oe(pad_scl_oe)
    );

    // bench-side views in the chain's field order (R2)
    logic [NI-1:0] pin_v, cin_v;
    logic [NO-1:0] co_v, pout_v;
    logic [NE-1:0] ce_v, poe_v;
    assign pin_v  = {pad_scl_i, pad_sda_i, pad_rx, pad_gpio_i};
    assign cin_v  = {core_scl_i, core_sda_i, core_rx, core_gpio_i};
    assign co_v   = {core_scl_o, core_sda_o, core_tx, core_gpio_o};
    assign pout_v = {pad_scl_o, pad_sda_o, pad_tx, pad_gpio_o};
    assign ce_v   = {core_scl_oe, core_sda_oe, core_gpio_oe};
    assign poe_v  = {pad_scl_oe, pad_sda_oe, pad_gpio_oe};

    int total = 0;
    int bad   = 0;

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic step();
        @(posedge tck);
        @(negedge tck);
    endtask

    task automatic drive(input logic [NI-1:0] p, input logic [NO-1:0] o, input logic [NE-1:0] e);
        {pad_scl_i, pad_sda_i, pad_rx, pad_gpio_i}   = p;
        {core_scl_o, core_sda_o, core_tx, core_gpio_o} = o;
        {core_scl_oe, core_sda_oe, core_gpio_oe}     = e;
        #0.1;
    endtask

    task automatic check_pass(input string tag);
        check({tag, " pad out"}, 32'(pout_v), 32'(co_v));
        check({tag, " pad oe"},  32'(poe_v),  32'(ce_v));
        check({tag, " core in"}, 32'(cin_v),  32'(pin_v));
    endtask

    task automatic check_ext(input string tag, input logic [L-1:0] w);
        check({tag, " pad out"}, 32'(pout_v), 32'(w[NI +: NO]));
        check({tag, " pad oe"},  32'(poe_v),  32'(w[NI+NO +: NE]));
        check({tag, " core in"}, 32'(cin_v),  32'(w[0 +: NI]));
    endtask

    task automatic set_ir(input logic [3:0] c);
        ir = c;
        step();
    endtask

    task automatic shift_word(input logic [L-1:0] w, output logic [L-1:0] got);
        shift_dr = 1'b1;
        for (int i = 0; i < L; i++) begin
            tdi    = w[i];
            got[i] = tdo;
            step();
        end
        shift_dr = 1'b0;
        tdi = 1'b0;
    endtask

    task automatic pulse_capture();
        capture_dr = 1'b1; step(); capture_dr = 1'b0;
    endtask

    task automatic pulse_update();
        update_dr = 1'b1; step(); update_dr = 1'b0;
    endtask

    // R8: reset state
    task automatic t_reset();
        check_pass("R8 reset pass");
        check("R8 reset tdo", 32'(tdo), 32'd0);
    endtask

    // R7: other code -> pass-through, strobes ignored
    task automatic t_other();
        logic [L-1:0] got;
        set_ir(4'd3);
        drive(7'h55, 7'h2A, 6'h3C); check_pass("R7 pattern a");
        drive(7'h7F, 7'h00, 6'h3F); check_pass("R7 pattern b");
        drive(7'h12, 7'h6D, 6'h05); check_pass("R7 pattern c");
        shift_word({L{1'b1}}, got);
        pulse_capture();
        pulse_update();
        check_pass("R7 after strobes");
        ir = 4'd0;
        #0.1;
        check_pass("R9 before edge");
        step();
        check("R7 latches untouched", 32'(pout_v), 32'd0);
        check("R7 enables untouched", 32'(poe_v), 32'd0);
        check("R7 core in untouched", 32'(cin_v), 32'd0);
        set_ir(4'd3);
    endtask

    // R1 R2 R3 R6: sample / capture / shift ordering
    task automatic t_sample();
        logic [L-1:0] got;
        logic [L-1:0] w;
        set_ir(4'd2);
        drive(7'h35, 7'h4C, 6'h2B);
        check_pass("R6 sample pass");
        pulse_capture();
        check_pass("R6 pass during capture");
        shift_word('0, got);
        check("R2 R3 captured image", 32'(got), 32'({6'h2B, 7'h4C, 7'h35}));
        check_pass("R6 pass after shift");
        w = 20'hA5C3E;
        shift_word(w, got);
        check("R1 zeros back", 32'(got), 32'd0);
        shift_word('0, got);
        check("R1 word back in order", 32'(got), 32'(w));
        // capture wins over shift in the same cycle
        capture_dr = 1'b1; shift_dr = 1'b1; tdi = 1'b1; step();
        capture_dr = 1'b0; shift_dr = 1'b0; tdi = 1'b0;
        shift_word('0, got);
        check("R3 capture over shift", 32'(got), 32'({6'h2B, 7'h4C, 7'h35}));
    endtask

    // R4 R5 R9: preload then external test
    task automatic t_extest();
        logic [L-1:0] got;
        logic [L-1:0] w1, w2;
        w1 = 20'h9B5D1;
        w2 = 20'h36A6B;
        shift_word(w1, got);
        pulse_update();
        check_pass("R6 preload keeps pass");
        ir = 4'd0;
        #0.1;
        check_pass("R9 not yet external");
        step();
        check_ext("R4 extest w1", w1);
        drive(7'h0F, 7'h71, 6'h11);
        check_ext("R4 core/pad ignored", w1);
        shift_word(w2, got);
        check_ext("R5 shift w/o update holds", w1);
        check("R5 readout w1", 32'(got), 32'(w1));
        // update and shift together
        shift_dr = 1'b1; update_dr = 1'b1; tdi = 1'b1; step();
        shift_dr = 1'b0; update_dr = 1'b0; tdi = 1'b0;
        check_ext("R5 update takes pre-shift", w2);
        shift_word('0, got);
        check("R5 chain moved once", 32'(got), 32'({1'b1, w2[L-1:1]}));
        // capture in external test takes pads in / core outs
        pulse_capture();
        shift_word('0, got);
        check("R3 capture in extest", 32'(got), 32'({6'h11, 7'h71, 7'h0F}));
        check_ext("R4 still w2", w2);
    endtask

    // R8: test-logic-reset while instruction stays external
    task automatic t_tlr();
        tlr = 1'b1; step(); tlr = 1'b0;
        check_pass("R8 tlr pass");
        step();
        check_ext("R8 latches cleared", '0);
    endtask

    initial begin
        trst_n = 1'b0; tlr = 1'b0; ir = 4'd3;
        capture_dr = 1'b0; shift_dr = 1'b0; update_dr = 1'b0; tdi = 1'b0;
        drive(7'h2D, 7'h53, 6'h1A);
        step(); step();
        trst_n = 1'b1;
        step();
        t_reset();
        t_other();
        t_sample();
        t_extest();
        t_tlr();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge tck);
        bad++;
        total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule